// File: doc/BRIEF.md
# Capacitance Converter Control and Status Register

This block is the digital register logic that sits beside a capacitance-to-digital converter. A byte-wide register port reaches an 8-bit control/status register and two threshold byte registers. Software uses the control register to power the converter up and to start conversions. It also enables a digital threshold comparator and reads back the busy state and the sticky event flags.

The converter reports its activity through single-cycle strobes: one when a conversion completes, one when a scan ends and one when a pin-monitor retry happens. Each completion strobe comes with the accumulated result. The block keeps a sticky flag for each kind of event. On each completion with the comparator enabled, it compares the result with the 16-bit threshold. Flags that the register write cannot reach are cleared through dedicated clear strobes. An interrupt output combines the three interrupt-capable flags, and each of them has its own enable input.

Top module: `capsense_ctl`

## Requirements
- R1: The control register sits at `CTRL_ADDR`. Its bits, from bit 7 down to bit 0, are: enable, scan-end flag, done flag, busy/start, comparator enable, reserved (reads 0), retry flag, comparator flag. The threshold low byte sits at `THLO_ADDR` and the high byte at `THHI_ADDR`, and both read back what was written. Any other address reads 0.
- R2: After reset every register bit is 0, and `cnv_enable`, `cnv_start` and `irq` are 0.
- R3: The enable bit (bit 7) is read/write, and `cnv_enable` follows it. 0 keeps the converter in low-power state.
- R4: A write of 1 to bit 4 starts a conversion only when `conv_mode` is 000, 110 or 111. A start produces a one-cycle `cnv_start` pulse in the cycle after the write. Any other mode, or a write of 0 to bit 4, has no effect.
- R5: Bit 4 reads 1 from the cycle after an accepted start until the cycle after `conv_done`. If a start and `conv_done` arrive in the same cycle, bit 4 stays 1.
- R6: `conv_done` sets the done flag (bit 5) and `scan_done` sets the scan-end flag (bit 6). Hardware never clears either flag. Software clears the done flag by writing 0 to bit 5, and clears the scan-end flag with `clr_eos`.
- R7: `retry_evt` sets the retry flag (bit 1), and only `clr_retry` clears it.
- R8: When `conv_done` arrives while comparator enable (bit 3) is already 1 and `result` is strictly greater than {high byte, low byte}, the comparator flag (bit 0) is set. An equal or smaller result, or a disabled comparator, leaves the flag unchanged. `clr_cmp` clears it.
- R9: When a set event and a clear (strobe or write of 0) arrive in the same cycle, the flag ends up set.
- R10: A control-register write leaves bits 6, 2, 1 and 0 unchanged.
- R11: `irq` is 1 exactly when (done flag and `ie_done`) or (scan-end flag and `ie_eos`) or (comparator flag and `ie_cmp`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| conv_mode | input | 3 | Conversion-mode field |
| conv_done | input | 1 | Conversion-complete strobe |
| scan_done | input | 1 | Scan-end strobe |
| retry_evt | input | 1 | Pin-monitor retry strobe |
| result | input | 16 | Accumulated conversion result |
| clr_eos | input | 1 | Clear strobe for the scan-end flag |
| clr_retry | input | 1 | Clear strobe for the retry flag |
| clr_cmp | input | 1 | Clear strobe for the comparator flag |
| ie_done | input | 1 | Interrupt enable for the done flag |
| ie_eos | input | 1 | Interrupt enable for the scan-end flag |
| ie_cmp | input | 1 | Interrupt enable for the comparator flag |
| cnv_enable | output | 1 | Converter enable |
| cnv_start | output | 1 | One-cycle conversion start pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 2-bit address with the control register at 0 and the threshold bytes at 1 and 2. With these values address 3 is left unmapped, so the zero read-back of an unused address can be reached. The 16-bit threshold can be set to values whose high and low bytes differ, so a result that wins only on the low byte separates a strict comparison from an equal one. Directed sequences drive same-cycle start/finish and set/clear collisions. A long random stretch then mixes writes, modes and strobes against the bench's own model.

// File: rtl/capsense_ctl.sv
module capsense_ctl #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] THLO_ADDR = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] THHI_ADDR = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [2:0]        conv_mode,
  input  logic              conv_done,
  input  logic              scan_done,
  input  logic              retry_evt,
  input  logic [15:0]       result,
  input  logic              clr_eos,
  input  logic              clr_retry,
  input  logic              clr_cmp,
  input  logic              ie_done,
  input  logic              ie_eos,
  input  logic              ie_cmp,
  output logic              cnv_enable,
  output logic              cnv_start,
  output logic              irq
);
  logic en_q, eos_q, done_q, busy_q, cmpen_q, pme_q, cmpf_q, start_q;
  logic [7:0] thlo_q, thhi_q;

  wire ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
  wire mode_ok  = (conv_mode == 3'b000) || (conv_mode == 3'b110) || (conv_mode == 3'b111);
  wire start_ok = ctrl_wr && bus_wdata[4] && mode_ok;
  wire above    = result > {thhi_q, thlo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; eos_q <= 1'b0; done_q <= 1'b0; busy_q <= 1'b0;
      cmpen_q <= 1'b0; pme_q <= 1'b0; cmpf_q <= 1'b0; start_q <= 1'b0;
      thlo_q <= 8'h00; thhi_q <= 8'h00;
    end else begin
      start_q <= start_ok;
      if (ctrl_wr) begin
        en_q    <= bus_wdata[7];
        cmpen_q <= bus_wdata[3];
      end
      if (bus_wr && bus_addr == THLO_ADDR) thlo_q <= bus_wdata;
      if (bus_wr && bus_addr == THHI_ADDR) thhi_q <= bus_wdata;

      if (start_ok)       busy_q <= 1'b1;
      else if (conv_done) busy_q <= 1'b0;

      if (conv_done)    done_q <= 1'b1;
      else if (ctrl_wr) done_q <= bus_wdata[5];

      if (scan_done)    eos_q <= 1'b1;
      else if (clr_eos) eos_q <= 1'b0;

      if (retry_evt)      pme_q <= 1'b1;
      else if (clr_retry) pme_q <= 1'b0;

      if (conv_done && cmpen_q && above) cmpf_q <= 1'b1;
      else if (clr_cmp)                  cmpf_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == CTRL_ADDR)
      bus_rdata = {en_q, eos_q, done_q, busy_q, cmpen_q, 1'b0, pme_q, cmpf_q};
    else if (bus_addr == THLO_ADDR)
      bus_rdata = thlo_q;
    else if (bus_addr == THHI_ADDR)
      bus_rdata = thhi_q;
  end

  assign cnv_enable = en_q;
  assign cnv_start  = start_q;
  assign irq = (done_q & ie_done) | (eos_q & ie_eos) | (cmpf_q & ie_cmp);
endmodule

// File: rtl/capsense_ctl_chk.sv
module capsense_ctl_chk #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [2:0]        conv_mode,
  input logic              conv_done,
  input logic              scan_done,
  input logic              retry_evt,
  input logic              clr_eos,
  input logic              cnv_start,
  input logic              busy_q,
  input logic              done_q,
  input logic              eos_q,
  input logic              pme_q,
  input logic              cmpf_q,
  input logic              cmpen_q
);
  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> $past(bus_wr && bus_addr == CTRL_ADDR && bus_wdata[4] &&
                        (conv_mode == 3'b000 || conv_mode == 3'b110 || conv_mode == 3'b111)));

  // R5
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> busy_q);

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(conv_done) && !cnv_start) |-> !busy_q);

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_done) |-> done_q);

  // R6
  eos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eos_q) |-> $past(clr_eos && !scan_done));

  // R7
  retry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retry_evt) |-> pme_q);

  // R8
  cmp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpf_q) |-> $past(conv_done && cmpen_q));
endmodule

bind capsense_ctl capsense_ctl_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .conv_mode(conv_mode), .conv_done(conv_done), .scan_done(scan_done),
  .retry_evt(retry_evt), .clr_eos(clr_eos), .cnv_start(cnv_start),
  .busy_q(busy_q), .done_q(done_q), .eos_q(eos_q), .pme_q(pme_q),
  .cmpf_q(cmpf_q), .cmpen_q(cmpen_q)
);

// File: tb/capsense_ctl_tb.sv
module capsense_ctl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [2:0] conv_mode = 0;
  logic conv_done = 0, scan_done = 0, retry_evt = 0;
  logic [15:0] result = 0;
  logic clr_eos = 0, clr_retry = 0, clr_cmp = 0;
  logic ie_done = 0, ie_eos = 0, ie_cmp = 0;
  logic cnv_enable, cnv_start, irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  capsense_ctl u_dut (.*);

  // behavioural reference state
  bit m_en, m_eos, m_done, m_busy, m_cmpen, m_pme, m_cmpf, m_start;
  int m_thr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_eos <= 0; m_done <= 0; m_busy <= 0; m_cmpen <= 0;
      m_pme <= 0; m_cmpf <= 0; m_start <= 0; m_thr <= 0;
    end else begin
      bit go, cw;
      cw = bus_wr && bus_addr == 0;
      go = cw && bus_wdata[4] && (conv_mode inside {3'd0, 3'd6, 3'd7});
      m_start <= go;
      if (cw) begin m_en <= bus_wdata[7]; m_cmpen <= bus_wdata[3]; end
      if (bus_wr && bus_addr == 1) m_thr <= (m_thr & 32'hFF00) | int'(bus_wdata);
      if (bus_wr && bus_addr == 2) m_thr <= (m_thr & 32'h00FF) | (int'(bus_wdata) << 8);
      m_busy <= go ? 1'b1 : (conv_done ? 1'b0 : m_busy);
      m_done <= conv_done ? 1'b1 : (cw ? bus_wdata[5] : m_done);
      m_eos  <= scan_done ? 1'b1 : (clr_eos ? 1'b0 : m_eos);
      m_pme  <= retry_evt ? 1'b1 : (clr_retry ? 1'b0 : m_pme);
      m_cmpf <= (conv_done && m_cmpen && int'(result) > m_thr) ? 1'b1 : (clr_cmp ? 1'b0 : m_cmpf);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_irq;
    if (bus_addr == 0) begin
      chk("R3 enable bit",    bus_rdata[7], m_en);
      chk("R6 scan-end flag", bus_rdata[6], m_eos);
      chk("R6 done flag",     bus_rdata[5], m_done);
      chk("R5 busy bit",      bus_rdata[4], m_busy);
      chk("R10 cmp enable",   bus_rdata[3], m_cmpen);
      chk("R1 reserved bit",  bus_rdata[2], 0);
      chk("R7 retry flag",    bus_rdata[1], m_pme);
      chk("R8 cmp flag",      bus_rdata[0], m_cmpf);
    end else if (bus_addr == 1) chk("R1 threshold low", bus_rdata, m_thr & 8'hFF);
    else if (bus_addr == 2)     chk("R1 threshold high", bus_rdata, (m_thr >> 8) & 8'hFF);
    else                        chk("R1 unmapped read", bus_rdata, 0);
    chk("R3 cnv_enable", cnv_enable, m_en);
    chk("R4 cnv_start", cnv_start, m_start);
    exp_irq = (m_done && ie_done) || (m_eos && ie_eos) || (m_cmpf && ie_cmp);
    chk("R11 irq", irq, exp_irq);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    bus_wr = 0; bus_addr = 0; conv_done = 0; scan_done = 0; retry_evt = 0;
    clr_eos = 0; clr_retry = 0; clr_cmp = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12;
    compare();                                  // R2 during reset
    rst_n = 1;
    tick();                                     // R2 after release
    chk("R2 reset ctrl", bus_rdata, 0);
    wr(1, 8'h34); wr(2, 8'h12);                 // R1 threshold 0x1234
    bus_addr = 1; tick(); bus_addr = 2; tick(); bus_addr = 3; tick();
    wr(0, 8'h80);                               // R3 enable
    conv_mode = 3; wr(0, 8'h90); tick();        // R4 rejected mode
    conv_mode = 0; wr(0, 8'h90); tick();        // R4 accepted, R5 busy
    result = 16'h1235; conv_done = 1; tick();   // R8 comparator off
    wr(0, 8'h88);                               // R10 cmpen, done cleared by write
    result = 16'h1234; conv_done = 1; tick();   // R8 equal: no set
    result = 16'h1235; conv_done = 1; tick();   // R8 greater by low byte
    clr_cmp = 1; tick();
    result = 16'h2200; conv_done = 1; clr_cmp = 1; tick(); // R9
    conv_mode = 6; bus_wr = 1; bus_wdata = 8'h98; conv_done = 1; tick(); // R5 collision
    conv_done = 1; tick();
    conv_mode = 7; wr(0, 8'h98); tick();
    conv_done = 1; bus_wr = 1; bus_wdata = 8'h88; tick(); // R9 done set beats write 0
    scan_done = 1; tick(); clr_eos = 1; tick();  // R6
    scan_done = 1; clr_eos = 1; tick();          // R9
    retry_evt = 1; tick(); clr_retry = 1; tick();// R7
    retry_evt = 1; clr_retry = 1; tick();        // R9
    conv_mode = 5; wr(0, 8'hFF); tick();         // R10 read-only bits kept, R4 no start
    ie_done = 1; tick(); ie_done = 0; ie_eos = 1; tick();
    ie_eos = 0; ie_cmp = 1; tick(); ie_cmp = 0; tick(); // R11
    wr(0, 8'h00); tick();                        // R3 disable
    for (int i = 0; i < 5000; i++) begin
      bus_addr = 2'($urandom_range(0, 3));
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_wdata = 8'($urandom);
      conv_mode = 3'($urandom);
      conv_done = ($urandom_range(0, 4) == 0);
      scan_done = ($urandom_range(0, 5) == 0);
      retry_evt = ($urandom_range(0, 6) == 0);
      result = 16'($urandom);
      clr_eos = ($urandom_range(0, 4) == 0);
      clr_retry = ($urandom_range(0, 4) == 0);
      clr_cmp = ($urandom_range(0, 4) == 0);
      ie_done = 1'($urandom); ie_eos = 1'($urandom); ie_cmp = 1'($urandom);
      tick();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule